// File: doc/BRIEF.md
# Programmable Clock Divider Search Engine

This block takes a requested output frequency in kHz and looks for the best divider settings for a programmable clock synthesizer. The synthesizer's VCO runs at twice a fixed reference multiplied by P/Q. A power-of-two post-divider, chosen by a 3-bit code, then divides the VCO down. The engine tries every legal post-divider code and every reference divider Q in a fixed order. For each pair it computes the feedback value P and the frequency that setting would give. It keeps the candidate closest to the request whose VCO frequency falls inside one of the synthesizer's tuning bands.

A single pulse on `start` launches a search. `busy` stays high while the search runs. `done` is a one-cycle pulse that marks the end. At that point `found` tells whether any legal setting exists. If one does, the winning P, Q, post-divider code, band index, achieved frequency and a packed 21-bit programming word are shown on the outputs. All divisions go through one shared restoring divider, which retires several quotient bits per clock.

Top module: `pll_param_search`

## Requirements
- R1: A `start` pulse while idle raises `busy` from the next cycle. `busy` stays high until the search ends. `done` is then high for exactly one cycle, with `busy` low in that same cycle.
- R2: `start` and `target_khz` are ignored while `busy` is high. The results belong to the target that was captured when the search began.
- R3: Post-divider codes 0 to 6 are tried in ascending order, and code c divides by 2^c. The VCO frequency for code c is target×2^c kHz. A code is skipped unless this value lies in 40000..120000 inclusive.
- R4: Q runs from 3 to 129 in ascending order inside each code. A Q is used only when floor(1431818/Q) lies in 20000..100000 inclusive.
- R5: P = floor(Q×vco×100 / (2×1431818)) + 1. The candidate is dropped unless 4 ≤ P ≤ 130.
- R6: The achieved frequency is floor(2×1431818×P / (Q×2^c×100)) kHz, and it is reported on `freq_khz`.
- R7: The winner has the smallest absolute difference between the achieved and requested frequency. A later candidate replaces the current best only if its difference is strictly smaller, so ties keep the earlier one.
- R8: The VCO band edges are 50000, 51000, 53200, 58500, 60700, 64400, 66800, 73500, 75600, 80900, 83200, 91500, 100000 and 120000. The band index is the largest i in 0..12 with edge[i] ≤ vco ≤ edge[i+1]. A candidate that matches no band is rejected.
- R9: The programming word is built from four fields: Q−2 in bits 6:0, the post-divider code in bits 9:7, P−3 in bits 16:10 and the band index in bits 20:17.
- R10: If no candidate is accepted, `found` is low and `prog_word`, `p_val`, `q_val`, `m_code`, `band_idx` and `freq_khz` are all zero.
- R11: After reset, `busy`, `done` and `found` are low and `prog_word` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch a search (ignored while busy) |
| target_khz | input | 17 | Requested output frequency in kHz |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle end-of-search pulse |
| found | output | 1 | A legal setting was accepted |
| p_val | output | 8 | Winning feedback value P |
| q_val | output | 8 | Winning reference divider Q |
| m_code | output | 3 | Winning post-divider code |
| band_idx | output | 4 | VCO band index of the winner |
| freq_khz | output | 18 | Achieved frequency in kHz |
| prog_word | output | 21 | Packed programming word |

## Verification
The hardest thing to drive from the ports is a search in which the smallest error belongs to a candidate whose VCO frequency matches no band. In that case the engine has to pass over the nearer candidate and keep a worse one. A second hard case is a VCO frequency that sits exactly on a shared band edge. Directed targets cover both. Targets whose legal VCO values fall only between 40000 and 49999 leave the engine with nothing accepted. Targets whose VCO lands on edges such as 51000 or 100000 exercise the last-match rule. Seeded random targets across the whole range then compare every reported field against a model computed in the bench. One search also receives a second `start` with a different target while it is busy.

// File: rtl/pll_srch_pkg.sv
package pll_srch_pkg;

   localparam int BAND_EDGES = 14;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_MCHK,
      ST_QCHK,
      ST_PWAIT,
      ST_TWAIT,
      ST_QNEXT,
      ST_MNEXT,
      ST_FIN
   } srch_state_t;

   function automatic logic [31:0] band_edge(input int i);
      case (i)
         0:       band_edge = 32'd50000;
         1:       band_edge = 32'd51000;
         2:       band_edge = 32'd53200;
         3:       band_edge = 32'd58500;
         4:       band_edge = 32'd60700;
         5:       band_edge = 32'd64400;
         6:       band_edge = 32'd66800;
         7:       band_edge = 32'd73500;
         8:       band_edge = 32'd75600;
         9:       band_edge = 32'd80900;
         10:      band_edge = 32'd83200;
         11:      band_edge = 32'd91500;
         12:      band_edge = 32'd100000;
         default: band_edge = 32'd120000;
      endcase
   endfunction

endpackage

// File: rtl/pll_srch_div.sv
module pll_srch_div #(
   parameter int W    = 32,
   parameter int STEP = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [W-1:0] num,
   input  logic [W-1:0] den,
   output logic         done,
   output logic [W-1:0] quot
);
   localparam int ROUNDS = W / STEP;
   localparam int CW     = $clog2(ROUNDS + 1);

   if (W % STEP != 0) begin : g_bad_step
      $error("pll_srch_div: W must be a multiple of STEP");
   end

   logic [W-1:0]  rem_q, quo_q, den_q, rem_n, quo_n;
   logic [CW-1:0] cnt_q;
   logic          run_q, done_q;

   always_comb begin
      logic [W:0] t;
      rem_n = rem_q;
      quo_n = quo_q;
      for (int k = 0; k < STEP; k++) begin
         t     = {rem_n, quo_n[W-1]};
         quo_n = {quo_n[W-2:0], 1'b0};
         if (t >= {1'b0, den_q}) begin
            t        = t - {1'b0, den_q};
            quo_n[0] = 1'b1;
         end
         rem_n = t[W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q  <= '0;
         quo_q  <= '0;
         den_q  <= '0;
         cnt_q  <= '0;
         run_q  <= 1'b0;
         done_q <= 1'b0;
      end else if (start) begin
         rem_q  <= '0;
         quo_q  <= num;
         den_q  <= den;
         cnt_q  <= CW'(ROUNDS);
         run_q  <= 1'b1;
         done_q <= 1'b0;
      end else if (run_q) begin
         rem_q  <= rem_n;
         quo_q  <= quo_n;
         cnt_q  <= cnt_q - 1'b1;
         done_q <= (cnt_q == CW'(1));
         run_q  <= (cnt_q != CW'(1));
      end else begin
         done_q <= 1'b0;
      end
   end

   assign done = done_q;
   assign quot = quo_q;

   AST_DIV_DEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> den != '0);  // R5
   AST_DIV_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);  // R6

endmodule

// File: rtl/pll_srch_band.sv
module pll_srch_band
   import pll_srch_pkg::*;
#(
   parameter int IW = 4
) (
   input  logic [31:0]   fvco,
   output logic          hit,
   output logic [IW-1:0] idx
);
   localparam int NB = BAND_EDGES - 1;

   if ((1 << IW) < NB) begin : g_bad_iw
      $error("pll_srch_band: IW too narrow for the band count");
   end

   logic [NB-1:0] match;

   for (genvar i = 0; i < NB; i++) begin : g_band
      assign match[i] = (fvco >= band_edge(i)) && (fvco <= band_edge(i + 1));
   end

   always_comb begin
      hit = 1'b0;
      idx = '0;
      for (int i = 0; i < NB; i++) begin
         if (match[i]) begin
            hit = 1'b1;
            idx = IW'(i);
         end
      end
   end

endmodule

// File: rtl/pll_param_search.sv
module pll_param_search
   import pll_srch_pkg::*;
#(
   parameter int TW      = 17,
   parameter int DIVW    = 32,
   parameter int DSTEP   = 4,
   parameter int FREF    = 1431818,
   parameter int QMIN    = 3,
   parameter int QMAX    = 129,
   parameter int MCODES  = 7,
   parameter int VCO_LO  = 40000,
   parameter int VCO_HI  = 120000,
   parameter int REFQ_LO = 20000,
   parameter int REFQ_HI = 100000,
   parameter int P_LO    = 4,
   parameter int P_HI    = 130,
   localparam int FW     = TW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [TW-1:0] target_khz,
   output logic          busy,
   output logic          done,
   output logic          found,
   output logic [7:0]    p_val,
   output logic [7:0]    q_val,
   output logic [2:0]    m_code,
   output logic [3:0]    band_idx,
   output logic [FW-1:0] freq_khz,
   output logic [20:0]   prog_word
);
   if (QMAX - 2 > 127 || P_HI - 3 > 127 || QMIN < 2 || P_LO < 3) begin : g_bad_range
      $error("pll_param_search: P/Q range does not fit the 7-bit word fields");
   end
   if (MCODES > 7 || DIVW < 32 || TW > DIVW - 8) begin : g_bad_width
      $error("pll_param_search: code count or datapath width out of range");
   end

   srch_state_t   state_q;
   logic [DIVW-1:0] tgt_q, best_err, fvco, div_num, div_den, div_quot, p_next, cand_err;
   logic [2:0]    mc_q, bm;
   logic [7:0]    q_q, p_q, bp, bq;
   logic [3:0]    bi, band_i;
   logic [FW-1:0] bf;
   logic          found_q, div_start, div_done, band_hit, q_ok, fvco_ok, p_ok;

   assign fvco    = tgt_q << mc_q;
   assign fvco_ok = (fvco >= DIVW'(VCO_LO)) && (fvco <= DIVW'(VCO_HI));
   assign q_ok    = (DIVW'(FREF) >= DIVW'(REFQ_LO) * DIVW'(q_q)) &&
                    (DIVW'(FREF) <  DIVW'(REFQ_HI + 1) * DIVW'(q_q));
   assign p_next  = div_quot + 1'b1;
   assign p_ok    = (p_next >= DIVW'(P_LO)) && (p_next <= DIVW'(P_HI));
   assign cand_err = (div_quot >= tgt_q) ? div_quot - tgt_q : tgt_q - div_quot;

   always_comb begin
      div_start = 1'b0;
      div_num   = DIVW'(q_q) * fvco * DIVW'(100);
      div_den   = DIVW'(2 * FREF);
      if (state_q == ST_QCHK && q_ok)
         div_start = 1'b1;
      if (state_q == ST_PWAIT) begin
         div_start = div_done && p_ok;
         div_num   = DIVW'(2 * FREF) * p_next;
         div_den   = DIVW'(q_q) * (DIVW'(1) << mc_q) * DIVW'(100);
      end
   end

   pll_srch_div #(.W(DIVW), .STEP(DSTEP)) u_div (
      .clk(clk), .rst_n(rst_n), .start(div_start), .num(div_num), .den(div_den),
      .done(div_done), .quot(div_quot)
   );

   pll_srch_band #(.IW(4)) u_band (.fvco(fvco[31:0]), .hit(band_hit), .idx(band_i));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         tgt_q    <= '0;
         mc_q     <= '0;
         q_q      <= '0;
         p_q      <= '0;
         best_err <= '1;
         bp <= '0; bq <= '0; bm <= '0; bi <= '0; bf <= '0;
         found_q  <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: if (start) begin
               tgt_q    <= DIVW'(target_khz);
               mc_q     <= '0;
               best_err <= '1;
               bp <= '0; bq <= '0; bm <= '0; bi <= '0; bf <= '0;
               found_q  <= 1'b0;
               state_q  <= ST_MCHK;
            end
            ST_MCHK: begin
               q_q     <= 8'(QMIN);
               state_q <= fvco_ok ? ST_QCHK : ST_MNEXT;
            end
            ST_QCHK: state_q <= q_ok ? ST_PWAIT : ST_QNEXT;
            ST_PWAIT: if (div_done) begin
               p_q     <= p_next[7:0];
               state_q <= p_ok ? ST_TWAIT : ST_QNEXT;
            end
            ST_TWAIT: if (div_done) begin
               if (cand_err < best_err && band_hit) begin
                  best_err <= cand_err;
                  bp <= p_q; bq <= q_q; bm <= mc_q; bi <= band_i;
                  bf <= div_quot[FW-1:0];
                  found_q <= 1'b1;
               end
               state_q <= ST_QNEXT;
            end
            ST_QNEXT: begin
               q_q     <= q_q + 1'b1;
               state_q <= (q_q == 8'(QMAX)) ? ST_MNEXT : ST_QCHK;
            end
            ST_MNEXT: begin
               mc_q    <= mc_q + 1'b1;
               state_q <= (mc_q == 3'(MCODES - 1)) ? ST_FIN : ST_MCHK;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy      = (state_q != ST_IDLE) && (state_q != ST_FIN);
   assign done      = (state_q == ST_FIN);
   assign found     = found_q;
   assign p_val     = bp;
   assign q_val     = bq;
   assign m_code    = bm;
   assign band_idx  = bi;
   assign freq_khz  = bf;
   assign prog_word = found_q ? {bi, bp[6:0] - 7'd3, bm, bq[6:0] - 7'd2} : 21'd0;

   AST_BUSY_ENDS_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);  // R1
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);  // R1
   AST_TARGET_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      busy && $past(busy) |-> $stable(tgt_q));  // R2
   AST_QCHK_VCO_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == ST_QCHK |-> fvco >= DIVW'(VCO_LO) && fvco <= DIVW'(VCO_HI));  // R3
   AST_BEST_NEVER_WORSE: assert property (@(posedge clk) disable iff (!rst_n)
      busy && $past(busy) |-> best_err <= $past(best_err));  // R7
   AST_RESULT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      done && found |-> p_val >= 8'(P_LO) && p_val <= 8'(P_HI) && q_val >= 8'(QMIN)
                        && q_val <= 8'(QMAX) && band_idx <= 4'd12);  // R5
   AST_NOTFOUND_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      done && !found |-> prog_word == 21'd0 && freq_khz == '0);  // R10

endmodule

// File: tb/pll_param_search_test.sv
module pll_param_search_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [16:0] target_khz = '0;
   logic        busy, done, found;
   logic [7:0]  p_val, q_val;
   logic [2:0]  m_code;
   logic [3:0]  band_idx;
   logic [17:0] freq_khz;
   logic [20:0] prog_word;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   pll_param_search uut (
      .clk(clk), .rst_n(rst_n), .start(start), .target_khz(target_khz),
      .busy(busy), .done(done), .found(found), .p_val(p_val), .q_val(q_val),
      .m_code(m_code), .band_idx(band_idx), .freq_khz(freq_khz), .prog_word(prog_word)
   );

   localparam longint FR = 1431818;
   longint edges[14] = '{50000, 51000, 53200, 58500, 60700, 64400, 66800,
                         73500, 75600, 80900, 83200, 91500, 100000, 120000};

   // expected result, recomputed from the requirements
   bit     e_found;
   longint e_p, e_q, e_m, e_i, e_f, e_err, e_word;

   task automatic model(input longint t);
      longint best;
      best = 64'h7FFF_FFFF_FFFF_FFFF;
      e_found = 0; e_p = 0; e_q = 0; e_m = 0; e_i = 0; e_f = 0; e_err = 0;
      for (int c = 0; c < 7; c++) begin
         longint vco;
         vco = t << c;
         if (vco < 40000 || vco > 120000) continue;
         for (int q = 3; q <= 129; q++) begin
            longint p, af, er, bidx;
            if (FR / q < 20000 || FR / q > 100000) continue;
            p = (q * vco * 100) / (2 * FR) + 1;
            if (p < 4 || p > 130) continue;
            af = (2 * FR * p) / (q * (64'd1 << c) * 100);
            er = (af > t) ? af - t : t - af;
            bidx = -1;
            for (int i = 0; i < 13; i++)
               if (vco >= edges[i] && vco <= edges[i + 1]) bidx = i;
            if (er < best && bidx >= 0) begin
               best = er; e_found = 1; e_p = p; e_q = q; e_m = c; e_i = bidx;
               e_f = af; e_err = er;
            end
         end
      end
      e_word = e_found ? ((e_i << 17) | ((e_p - 3) << 10) | (e_m << 7) | (e_q - 2)) : 0;
   endtask

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic run(input longint t, input bit poke);
      int wd;
      model(t);
      @(negedge clk);
      target_khz = 17'(t);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy === 1'b1, "R1 busy after start", longint'(busy), 1);
      if (poke) begin
         target_khz = 17'(t ^ 17'h0F0F);
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      wd = 0;
      while (done !== 1'b1 && wd < 20000) begin
         @(negedge clk);
         wd++;
      end
      if (wd >= 20000) begin
         chk(1'b0, "R1 watchdog expired", wd, 20000);
         return;
      end
      chk(busy === 1'b0, "R1 busy low with done", longint'(busy), 0);
      chk(found === e_found, poke ? "R2 found after ignored start" : "R8 found",
          longint'(found), longint'(e_found));
      chk(prog_word == 21'(e_word), poke ? "R2 word" : (e_found ? "R9 word" : "R10 word"),
          prog_word, e_word);
      chk(freq_khz == 18'(e_f), "R6 freq", freq_khz, e_f);
      if (e_found) begin
         longint aerr;
         aerr = (freq_khz > t) ? freq_khz - t : t - freq_khz;
         chk(aerr == e_err, "R7 error", aerr, e_err);
         chk(p_val == 8'(e_p), "R5 P", p_val, e_p);
         chk(q_val == 8'(e_q), "R4 Q", q_val, e_q);
         chk(m_code == 3'(e_m), "R3 code", m_code, e_m);
         chk(band_idx == 4'(e_i), "R8 band", band_idx, e_i);
      end else begin
         chk(p_val == 0 && q_val == 0 && band_idx == 0, "R10 fields zero", p_val, 0);
      end
      @(negedge clk);
      chk(done === 1'b0, "R1 done single cycle", longint'(done), 0);
   endtask

   initial begin
      int unsigned seed_init;
      repeat (3) @(negedge clk);
      chk(busy === 1'b0 && done === 1'b0, "R11 busy/done reset", longint'(busy), 0);
      chk(found === 1'b0 && prog_word == 21'd0, "R11 found/word reset", prog_word, 0);
      rst_n = 1'b1;
      @(negedge clk);
      run(25175, 0);
      run(28322, 1);
      run(32500, 0);
      run(0, 0);       // no code reaches the VCO window
      run(625, 0);     // only VCO 40000: no band
      run(20000, 0);   // code 1 gives 40000 without band, code 2 valid
      run(782, 0);
      run(25500, 0);   // VCO 51000 edge
      run(50000, 0);   // VCO 100000 edge
      run(130000, 0);  // above the VCO window
      seed_init = $urandom(32'd7715);
      for (int n = 0; n < 16; n++) run(longint'($urandom_range(125000, 300)), n == 5);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule